// File: doc/BRIEF.md
# Programmable Delay and Pulse Generator

A clocked timing element that delays a single-bit input by a base latency of two clock steps plus a programmed 8-bit step count. A second output supplies either a fixed-latency reference copy of the input or a one-shot pulse. The pulse starts on a rising input edge and lasts for the programmed number of cycles.

A mode bit picks between two output pairings:

- **Delay pairing:** a same-polarity delayed copy on the main output, with the fixed reference on the second output.
- **Pulse pairing:** an inverted delayed copy on the main output, with the one-shot on the second output.

Feeding the inverted copy back to the input makes the block a ring oscillator, and the programmed code sets its period. The delay is held as a full sample history. Any number of input edges can be in flight at once, so pulses much shorter than the delay are reproduced exactly.

Edge numbering used below: sample x(s) is the value on `in_i` at rising clock edge s. "After edge n" means the output value in the cycle that follows edge n. c(n) is `code_i` sampled at edge n. Samples taken before reset release count as 0.

Top module: `pdg_timing_element`

## Requirements
- R1: While `rst_ni` is low, with `mode_i`=0, both outputs are 0. The sample history clears, so after release every sample older than the first post-reset edge reads as 0.
- R2: With `mode_i`=0, `out_o` after edge n equals x(n-2-c(n)). A code of 0 still gives a latency of 2 edges.
- R3: With `mode_i`=0, `ref_pwm_o` after edge n equals x(n-3) for any code, which is one edge longer than the code-0 latency.
- R4: At code 255, `out_o` reproduces every input pulse after a delay of 257 edges. This holds even when the input period is far shorter than the delay, so many edges are in flight at once.
- R5: A code change applies at the first edge that samples it. The tap follows c(n) directly, with no settling interval.
- R6: With `mode_i`=1, `out_o` after edge n equals the inverse of x(n-2-c(n)).
- R7: A rising input edge, where x(s-1)=0 and x(s)=1, triggers at edge s+2 if the pulse is idle. The pulse is then high after edges s+2 through s+1+c(s+2), and that code is captured at the trigger edge. With `mode_i`=1 the pulse appears on `ref_pwm_o`. The pulse logic runs in both modes.
- R8: A trigger that finds the pulse high is discarded. This includes a trigger on the edge where the pulse ends. A new pulse can start no earlier than one edge after the previous one has returned low.
- R9: A trigger whose captured code is 0 produces no pulse.
- R10: With `mode_i`=1 and `out_o` fed back to `in_i`, starting from a cleared history, `out_o` toggles every 3+code cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | 1 | Waveform to delay or to trigger on |
| code_i | input | 8 | Programmed step count |
| mode_i | input | 1 | 0: delay and reference; 1: inverted delay and pulse |
| out_o | output | 1 | Delayed copy, inverted when `mode_i`=1 |
| ref_pwm_o | output | 1 | Reference copy (`mode_i`=0) or one-shot pulse (`mode_i`=1) |

## Verification
The collision that matters is a fresh rising edge reaching the pulse logic on the same edge that the running pulse finishes. Getting it wrong either stretches the pulse or restarts it with no low cycle. The bench provokes it with a pulse train whose rising edges recur at exactly the programmed length, so every second trigger lands on a pulse's last edge. A behavioural model built from trigger and end edge numbers judges each cycle, and the inverted delayed output is compared at the same time.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  typedef enum logic {
    MODE_DELAY = 1'b0,
    MODE_PULSE = 1'b1
  } pdg_mode_e;
endpackage

// File: rtl/pdg_history.sv
module pdg_history #(
  parameter int CODE_W   = 8,
  parameter int BASE_LAT = 2,
  parameter int REF_LAT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              dly_o,
  output logic              ref_o,
  output logic              rise_o
);
  localparam int DEPTH = (1 << CODE_W) + BASE_LAT;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] hist_q;
  logic [IDX_W-1:0] tap_idx;
  logic             dly_q, ref_q;

  // one flop per stage; hist_q[k] holds the sample taken k edges ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q[0] <= 1'b0;
    else         hist_q[0] <= in_i;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[g] <= 1'b0;
      else         hist_q[g] <= hist_q[g-1];
    end
  end

  assign tap_idx = IDX_W'(BASE_LAT - 1) + IDX_W'(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      dly_q <= hist_q[tap_idx];
      ref_q <= hist_q[REF_LAT-1];
    end
  end

  assign dly_o  = dly_q;
  assign ref_o  = ref_q;
  // edge seen so that the pulse register rises in step with a code-0 delay
  assign rise_o = hist_q[BASE_LAT-1] & ~hist_q[BASE_LAT];
endmodule

// File: rtl/pdg_one_shot.sv
module pdg_one_shot #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [CODE_W-1:0] len_i,
  output logic              pulse_o
);
  logic              pulse_q;
  logic [CODE_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      rem_q   <= '0;
    end else if (!pulse_q) begin
      if (trig_i && (len_i != '0)) begin
        pulse_q <= 1'b1;
        rem_q   <= len_i - CODE_W'(1);
      end
    end else if (rem_q == '0) begin
      pulse_q <= 1'b0;
    end else begin
      rem_q <= rem_q - CODE_W'(1);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/pdg_out_sel.sv
module pdg_out_sel
  import pdg_pkg::*;
(
  input  logic mode_i,
  input  logic dly_i,
  input  logic ref_i,
  input  logic pulse_i,
  output logic out_o,
  output logic ref_pwm_o
);
  pdg_mode_e mode;
  assign mode = pdg_mode_e'(mode_i);

  always_comb begin
    if (mode == MODE_PULSE) begin
      out_o     = ~dly_i;
      ref_pwm_o = pulse_i;
    end else begin
      out_o     = dly_i;
      ref_pwm_o = ref_i;
    end
  end
endmodule

// File: rtl/pdg_timing_element.sv
module pdg_timing_element #(
  parameter int CODE_W   = 8,
  parameter int BASE_LAT = 2,
  parameter int REF_LAT  = BASE_LAT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              mode_i,
  output logic              out_o,
  output logic              ref_pwm_o
);
  logic dly, ref_copy, rise, pulse;

  pdg_history #(
    .CODE_W  (CODE_W),
    .BASE_LAT(BASE_LAT),
    .REF_LAT (REF_LAT)
  ) u_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (in_i),
    .code_i(code_i),
    .dly_o (dly),
    .ref_o (ref_copy),
    .rise_o(rise)
  );

  pdg_one_shot #(
    .CODE_W(CODE_W)
  ) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (rise),
    .len_i  (code_i),
    .pulse_o(pulse)
  );

  pdg_out_sel u_sel (
    .mode_i   (mode_i),
    .dly_i    (dly),
    .ref_i    (ref_copy),
    .pulse_i  (pulse),
    .out_o    (out_o),
    .ref_pwm_o(ref_pwm_o)
  );
endmodule

// File: rtl/pdg_timing_element_chk.sv
module pdg_timing_element_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_i,
  input logic [CODE_W-1:0] code_i,
  input logic              mode_i,
  input logic              out_o,
  input logic              ref_pwm_o,
  input logic              pulse_i
);
  logic [2:0]      cyc_q;
  logic [CODE_W:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      hi_q  <= '0;
    end else begin
      if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
      hi_q <= pulse_i ? hi_q + (CODE_W+1)'(1) : '0;
    end
  end

  assert_dly_code0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd3 && !mode_i && $past(code_i) == '0) |-> (out_o == $past(in_i, 3)));

  assert_ref_lat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd4 && !mode_i) |-> (ref_pwm_o == $past(in_i, 4)));

  assert_inv_code0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd3 && mode_i && $past(code_i) == '0) |-> (out_o == !$past(in_i, 3)));

  assert_pulse_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd4 && $rose(pulse_i)) |-> ($past(in_i, 3) && !$past(in_i, 4)));

  assert_pulse_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> (hi_q <= (CODE_W+1)'((1 << CODE_W) - 2)));

  assert_pulse_on_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> (ref_pwm_o == pulse_i));

  assert_no_zero_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> ($past(code_i) != '0));
endmodule

bind pdg_timing_element pdg_timing_element_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .in_i     (in_i),
  .code_i   (code_i),
  .mode_i   (mode_i),
  .out_o    (out_o),
  .ref_pwm_o(ref_pwm_o),
  .pulse_i  (pulse)
);

// File: tb/pdg_timing_element_tb.sv
`timescale 1ns/1ps
module pdg_timing_element_tb_top;
  localparam int MAXE = 10000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_s = 1'b0;
  logic [7:0] code_s = '0;
  logic       mode_s = 1'b0;
  logic       out_s, rp_s;

  int    checks = 0;
  int    fails = 0;
  int    n = 0;
  int    pstart = -10;
  int    pend = -10;
  string otag = "R2";
  string rtag = "R3";
  bit    xin[0:MAXE-1];
  int    cd[0:MAXE-1];

  always #2.5 clk = ~clk;

  pdg_timing_element dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_s), .code_i(code_s),
    .mode_i(mode_s), .out_o(out_s), .ref_pwm_o(rp_s)
  );

  function automatic bit xv(int i);
    return (i >= 1) ? xin[i] : 1'b0;
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %0b expected %0b", tag, what, n, act, exp);
    end
  endtask

  // behavioural reference, compared on every edge after reset
  always @(posedge clk) begin
    if (rst_n) begin
      n++;
      xin[n] = in_s;
      cd[n] = int'(code_s);
      if (xv(n-2) && !xv(n-3) && cd[n] != 0 && n >= pend + 1) begin
        pstart = n;
        pend = n + cd[n];
      end
      #1;
      chk(otag, out_s, mode_s ^ xv(n - 2 - cd[n]), "out");
      if (mode_s) chk(rtag, rp_s, (n >= pstart && n < pend), "pulse");
      else        chk("R3", rp_s, xv(n - 3), "ref");
    end
  end

  // kind: 0 random, 1 square (period p, high w), 2 sparse, 3 loopback, 4 hold low
  task automatic run(int cycles, bit mode, int code, int kind, int p, int w,
                     string ot, string rt);
    logic prev;
    int   last;
    prev = out_s;
    last = -1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      otag = ot;
      rtag = rt;
      mode_s = mode;
      code_s = 8'(code);
      case (kind)
        0: in_s = 1'($urandom_range(0, 1));
        1: in_s = ((i % p) < w);
        2: in_s = ($urandom_range(0, 3) == 0);
        3: begin
          in_s = out_s;
          if (i > 0 && out_s != prev) begin
            if (last >= 0) chk("R10", ((i - last) == code + 3), 1'b1, "half period");
            last = i;
          end
          prev = out_s;
        end
        default: in_s = 1'b0;
      endcase
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", out_s, 1'b0, "out in reset");
    chk("R1", rp_s, 1'b0, "ref in reset");
    @(negedge clk);
    rst_n = 1'b1;
    run(300, 0, 0,   0, 1,  1, "R2", "R3");
    run(300, 0, 7,   0, 1,  1, "R2", "R3");
    run(700, 0, 255, 1, 20, 3, "R4", "R3");
    run(200, 0, 40,  0, 1,  1, "R5", "R3");
    run(100, 0, 3,   0, 1,  1, "R5", "R3");
    run(100, 0, 200, 0, 1,  1, "R5", "R3");
    run(600, 1, 10,  2, 1,  1, "R6", "R7");
    run(300, 1, 6,   1, 6,  2, "R6", "R8");
    run(200, 1, 0,   0, 1,  1, "R6", "R9");
    run(270, 1, 3,   4, 1,  1, "R6", "R7");
    run(300, 1, 3,   3, 1,  1, "R10", "R7");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule